// File: doc/BRIEF.md
# I2C Register Target with Locked Read Address

This block is the serial front end of a small power-management register file. It watches a two-wire bus through oversampled SCL and SDA inputs, answers one 7-bit target address and turns bus traffic into single-cycle read and write strobes on an 8-bit register port. A write transfer carries a subaddress first, then any number of data bytes. The register address steps by one after every byte moved in either direction, so long bursts need only one subaddress.

A read-lock input, normally wired to a bit of the register file itself, changes only the read path. While it is high, every read byte comes from register 0x00, the internal address pointer is left alone, and no subaddress write has to come first. A controller that can only issue read commands can therefore fetch a temperature value. Writes still use the pointer, and that includes the write that clears the lock bit.

The block pulls SDA low through an output enable and never drives it high. Its outputs change only after a falling SCL edge has been seen, so the level on the bus stays put while SCL is high. Clock stretching, general call and 10-bit addressing are not part of the block.

Top module: `pmic_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1001000 (group 1001, device 000) is acknowledged by pulling SDA low during the ninth clock. Bit 0 of that byte selects a read (1) or a write (0).
- R2: An address byte with any other upper seven bits gets no acknowledge, and the block drives SDA on no clock and strobes no write until the next START.
- R3: In a write transfer, the byte after the address is taken as the subaddress and acknowledged. Each later byte is acknowledged and written, with one single-cycle reg_we pulse carrying reg_wdata to reg_addr.
- R4: After every data byte written, the address pointer steps by one, so consecutive bytes of one transfer land in consecutive registers.
- R5: In a read transfer with read_lock low, bytes come from the pointer and the pointer steps by one after each byte. A read reached by a repeated START after a subaddress write starts at that subaddress.
- R6: A controller NACK after a read byte ends the read. SDA is released and no further register fetch takes place.
- R7: With read_lock high, every read byte is fetched from address 0x00, no subaddress write is needed, and the pointer does not move.
- R8: Writes behave the same whatever the level of read_lock, including a write that clears the lock bit. Afterwards, reads follow the pointer again.
- R9: Each byte sent to the controller is fetched with exactly one single-cycle reg_re pulse, so that clear-on-read status bits can clear. A read never coincides with a write strobe.
- R10: sda_oe changes only while SCL is low. It is stable across every cycle in which SCL is high on two consecutive samples.
- R11: After reset and after a STOP, SDA is released. A START or repeated START in the middle of a byte restarts reception at the address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| read_lock | input | 1 | Forces reads to address 0x00 without pointer stepping |
| reg_addr | output | ADDR_W | Register address for the current strobe |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Read data returned in the same cycle as reg_re |
| reg_re | output | 1 | Single-cycle register read strobe |

## Verification
Some properties hold on every cycle, and the checker watches these: the write and read strobes are single-cycle pulses and never overlap, sda_oe holds still while SCL stays high, and a fetch made under read_lock always presents address 0x00. Other behaviours depend on a whole transfer and only the directed scenarios can show them. These are address matching and silence on a foreign address, the stepping of the pointer across write and read bursts, the start of a read at a subaddress after a repeated START, the end of a read on NACK, the way a locked read leaves the pointer untouched, and writes that clear the lock.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic cond_start,
  output logic cond_stop
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_prev, sda_prev;
  logic              scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign scl_rise   = scl_s & ~scl_prev;
  assign scl_fall   = ~scl_s & scl_prev;
  // data edges while the clock is held high mark bus conditions
  assign cond_start = scl_s & scl_prev & sda_prev & ~sda_s;
  assign cond_stop  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_reg_pointer.sv
module i2c_reg_pointer #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);

  logic [ADDR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (load | inc) ptr <= ptr_d;
  end

endmodule

// File: rtl/pmic_i2c_target.sv
module pmic_i2c_target
  import pmic_i2c_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [3:0]  GROUP_ID    = 4'b1001,
  parameter logic [2:0]  DEVICE_ID   = 3'b000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              read_lock,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_re
);

  localparam logic [6:0]       TARGET_ADDR = {GROUP_ID, DEVICE_ID};
  localparam int               CNT_W       = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST    = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, cond_start, cond_stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .cond_start (cond_start),
    .cond_stop  (cond_stop)
  );

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              oe_q, oe_d;
  logic              ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr;

  i2c_reg_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ADDR_W'(sh_q)),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    nack_d   = nack_q;
    oe_d     = oe_q;
    reg_we   = 1'b0;
    reg_re   = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    if (cond_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (cond_stop) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == TARGET_ADDR) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_ACK_ADDR;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_SUB) begin
              oe_d     = 1'b1;
              ptr_load = 1'b1;
              state_d  = ST_ACK_SUB;
            end else begin
              oe_d    = 1'b1;
              reg_we  = 1'b1;
              ptr_inc = 1'b1;
              state_d = ST_ACK_WDATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (scl_fall) begin
            if (rw_q) begin
              reg_re  = 1'b1;
              ptr_inc = ~read_lock;
              sh_d    = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDATA;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_SUB;
            end
          end
        end
        ST_ACK_SUB, ST_ACK_WDATA: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d    = 1'b0;
              cnt_d   = '0;
              state_d = ST_RACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_d = sda_s;
          if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              reg_re  = 1'b1;
              ptr_inc = ~read_lock;
              sh_d    = reg_rdata;
              oe_d    = ~reg_rdata[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_wdata = sh_q;
  assign reg_addr  = (rw_q && read_lock) ? '0 : ptr;

endmodule

// File: rtl/pmic_i2c_target_chk.sv
module pmic_i2c_target_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              read_lock,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re
);

  // R3: a byte write is one strobe wide
  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R9: one fetch strobe per byte, never stretched
  p_re_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);

  // R9: reads and writes are never strobed together
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_re && reg_we));

  // R10: the line held by the target does not move while SCL is high
  p_sda_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  // R7: a locked fetch always targets register zero
  p_lock_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && read_lock) |-> (reg_addr == '0));

endmodule

bind pmic_i2c_target pmic_i2c_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .read_lock (read_lock),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_re    (reg_re)
);

// File: tb/pmic_i2c_target_bench.sv
`timescale 1ns/1ps
module pmic_i2c_target_bench;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_ctrl = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic       read_lock;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       reg_re;
  logic [7:0] regs [32];
  int         total = 0;
  int         bad = 0;
  int         re_cnt = 0;
  int         oe_cnt = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line  = sda_ctrl & ~sda_oe;
  assign reg_rdata = regs[reg_addr[4:0]];
  assign read_lock = regs[17][0];

  pmic_i2c_target u_pmic_i2c_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .read_lock (read_lock),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .reg_re    (reg_re)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= 8'(i * 7 + 3);
    end else if (reg_we) begin
      regs[reg_addr[4:0]] <= reg_wdata;
    end
  end

  always @(posedge clk) begin
    if (reg_re) re_cnt <= re_cnt + 1;
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  task automatic wait_q(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_ctrl = 1'b1; wait_q(1);
    scl = 1'b1;      wait_q(1);
    sda_ctrl = 1'b0; wait_q(1);
    scl = 1'b0;      wait_q(1);
  endtask

  task automatic bus_stop();
    sda_ctrl = 1'b0; wait_q(1);
    scl = 1'b1;      wait_q(1);
    sda_ctrl = 1'b1; wait_q(1);
  endtask

  task automatic put_bit(logic b);
    sda_ctrl = b; wait_q(1);
    scl = 1'b1;   wait_q(2);
    scl = 1'b0;   wait_q(1);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_ctrl = 1'b1; wait_q(1);
    scl = 1'b1;      wait_q(1);
    acked = ~sda_line;
    wait_q(1);
    scl = 1'b0;      wait_q(1);
  endtask

  task automatic recv_byte(logic ack, output logic [7:0] b);
    logic s1, s2;
    logic steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_ctrl = 1'b1; wait_q(1);
      scl = 1'b1;
      @(negedge clk); s1 = sda_line;
      wait_q(1);
      s2 = sda_line;
      b[i] = s2;
      if (s1 !== s2) steady = 1'b0;
      wait_q(1);
      scl = 1'b0;      wait_q(1);
    end
    chk("R10", "data steady while SCL high", 32'(steady), 32'd1);
    put_bit(~ack);
  endtask

  task automatic write_regs(logic [7:0] sub, logic [7:0] d0, int n, string req);
    logic a;
    bus_start();
    send_byte(8'h90, a); chk("R1", "address ack", 32'(a), 32'd1);
    send_byte(sub, a);   chk(req, "subaddress ack", 32'(a), 32'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i * 17), a);
      chk(req, "data ack", 32'(a), 32'd1);
    end
    bus_stop();
    chk("R11", "released after stop", 32'(sda_oe), 32'd0);
  endtask

  task automatic t_reset();
    chk("R11", "sda_oe after reset", 32'(sda_oe), 32'd0);
    chk("R11", "no strobes after reset", 32'({reg_we, reg_re}), 32'd0);
  endtask

  task automatic t_write_single();
    write_regs(8'h04, 8'h5A, 1, "R3");
    chk("R3", "reg 4 written", 32'(regs[4]), 32'h5A);
  endtask

  task automatic t_write_burst();
    write_regs(8'h08, 8'hA1, 3, "R4");
    chk("R4", "reg 8", 32'(regs[8]), 32'hA1);
    chk("R4", "reg 9", 32'(regs[9]), 32'hB2);
    chk("R4", "reg 10", 32'(regs[10]), 32'hC3);
  endtask

  task automatic t_bad_addr();
    logic a;
    int oe0 = oe_cnt;
    bus_start();
    send_byte(8'h92, a); chk("R2", "foreign address not acked", 32'(a), 32'd0);
    send_byte(8'h0C, a); chk("R2", "following byte not acked", 32'(a), 32'd0);
    send_byte(8'hEE, a);
    bus_stop();
    chk("R2", "SDA never driven", 32'(oe_cnt - oe0), 32'd0);
    chk("R2", "reg 12 untouched", 32'(regs[12]), 32'h57);
  endtask

  task automatic t_read_burst();
    logic a;
    logic [7:0] d;
    int re0;
    bus_start();
    send_byte(8'h90, a);
    send_byte(8'h08, a);
    bus_start();
    re0 = re_cnt;
    send_byte(8'h91, a); chk("R1", "read address ack", 32'(a), 32'd1);
    recv_byte(1'b1, d);  chk("R5", "first byte from subaddress", 32'(d), 32'hA1);
    recv_byte(1'b1, d);  chk("R5", "second byte stepped", 32'(d), 32'hB2);
    recv_byte(1'b0, d);  chk("R5", "third byte stepped", 32'(d), 32'hC3);
    wait_q(1);
    chk("R6", "released after NACK", 32'(sda_oe), 32'd0);
    chk("R9", "one fetch per byte", 32'(re_cnt - re0), 32'd3);
    bus_stop();
    chk("R6", "no fetch after NACK", 32'(re_cnt - re0), 32'd3);
  endtask

  task automatic t_start_abort();
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    write_regs(8'h02, 8'h33, 1, "R11");
    chk("R11", "restart mid-byte then write", 32'(regs[2]), 32'h33);
  endtask

  task automatic t_locked();
    logic a;
    logic [7:0] d;
    int re0;
    write_regs(8'h11, 8'h01, 1, "R8");
    chk("R8", "lock bit set by write", 32'(read_lock), 32'd1);
    bus_start();
    re0 = re_cnt;
    send_byte(8'h91, a); chk("R7", "locked read address ack", 32'(a), 32'd1);
    recv_byte(1'b1, d);  chk("R7", "locked byte 0", 32'(d), 32'h03);
    recv_byte(1'b0, d);  chk("R7", "locked byte 1 no step", 32'(d), 32'h03);
    bus_stop();
    chk("R9", "locked fetch count", 32'(re_cnt - re0), 32'd2);
    write_regs(8'h05, 8'h77, 1, "R8");
    chk("R8", "write while locked", 32'(regs[5]), 32'h77);
    write_regs(8'h11, 8'h00, 1, "R8");
    chk("R8", "lock cleared by write", 32'(read_lock), 32'd0);
    bus_start();
    send_byte(8'h91, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R7", "pointer untouched by locked reads", 32'(d), 32'h81);
    bus_start();
    send_byte(8'h90, a);
    send_byte(8'h05, a);
    bus_start();
    send_byte(8'h91, a);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R8", "unlocked read of locked write", 32'(d), 32'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_single();
    t_write_burst();
    t_bad_addr();
    t_read_burst();
    t_start_abort();
    t_locked();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule